// File: doc/BRIEF.md
# Fuzzy Inference Request Arbiter

This block chooses one winner among up to three processors that ask for the same shared memory module in the same cycle. Each processor comes with a measure of how often it has recently been served, its acceptance rate. The arbiter turns these rates into a priority score with a small fuzzy inference engine, so that a processor that keeps losing rises in priority over time. It does not rotate or fix the order.

A request round starts with a one-cycle `start_i` strobe carrying a request vector and one 8-bit rate per requester. Each rate is first mapped to low, medium and high membership grades. A nine-rule base pairs the requester's own grades with the strongest grade among its active competitors. The rules combine their antecedents with a minimum, and their singleton outputs are merged by maximum. A weighted-average defuzzifier then gives the score, and it uses a bit-serial divider for each requester. The highest score wins. When only one processor asks, it is granted at once with no inference. Losers get no grant and must ask again in a later round.

Top module: `fuzzy_req_arbiter`

## Requirements
- R1: While `rst` is high, and in every cycle without a valid grant, `grant_o` is all zeros and `grant_valid_o` is low.
- R2: When `start_i` is sampled with exactly one bit of `req_i` set, `grant_o` equals `req_i` and `grant_valid_o` is high, both in the cycle right after that sampling edge and for that one cycle only.
- R3: When `start_i` is sampled with `req_i` all zeros, no grant and no valid flag are produced.
- R4: When `start_i` is sampled with two or three request bits set, `grant_valid_o` is high for one cycle, ten clock edges after the sampling edge (eight divider steps plus two). During that cycle `grant_o` is one-hot.
- R5: Requester i's rate is `rate_i[8*i+7:8*i]`, an unsigned fraction where 255 means 1.0. For a rate r up to 128, the grades are low = 128-r, medium = r and high = 0. For r above 128, they are low = 0, medium = 255-r and high = r-128.
- R6: For each requester, each competitor grade is the maximum of that grade over the other requesting inputs. Each of the nine rules pairs one own set x with one competitor set y, where low=0, medium=1 and high=2. A rule's strength is the minimum of the two grades, and its consequent level is 2+y-x.
- R7: The weight of each of the five levels is the maximum strength among the rules that map to it. Level k carries the singleton value min(64k, 255). The score is the floor of the sum of weight times singleton, divided by the sum of the weights.
- R8: The winner is the requesting input with the highest score. On a tie the lowest index wins. A non-requesting input is never granted.
- R9: A `start_i` that arrives while a multi-request round is still being computed is ignored. It produces no grant and does not change the result of the round in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that samples `req_i` and `rate_i` |
| req_i | input | 3 | Request vector, bit i for requester i |
| rate_i | input | 24 | Packed acceptance rates, 8 bits per requester |
| grant_o | output | 3 | One-hot grant, all zeros when not valid |
| grant_valid_o | output | 1 | High for one cycle when `grant_o` holds a decision |

## Verification
Extreme pairs (0 against 255, in both orders) show that a starved requester beats a well-served one, whatever its position. Equal rates on two and on three inputs leave only the tie rule to decide, which separates lowest-index selection from any other order. A deterministic pseudo-random sweep over two- and three-input rates is compared with an independent integer model of fuzzification, rule firing, aggregation and floor division. Single-request, empty and overlapping strobes show apart the bypass latency, the absence of output, and the ignoring of a strobe that arrives during a busy round.

// File: rtl/fra_pkg.sv
package fra_pkg;

    parameter int RATE_W = 8;
    localparam int RATE_MAX = (1 << RATE_W) - 1;
    localparam int KNEE     = 1 << (RATE_W - 1);
    localparam int GRADE_W  = RATE_W;
    localparam int NSET     = 3;
    localparam int NLEVEL   = 2 * NSET - 1;
    localparam int AGG_W    = GRADE_W + $clog2(NLEVEL) + 1;
    localparam int NUM_W    = AGG_W + RATE_W;

    typedef logic [RATE_W-1:0]  rate_t;
    typedef logic [GRADE_W-1:0] grade_t;
    typedef logic [AGG_W-1:0]   wsum_t;
    typedef logic [NUM_W-1:0]   wnum_t;

    typedef struct packed {
        grade_t lo;
        grade_t md;
        grade_t hi;
    } memb_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INFER,
        ST_DIVIDE
    } arb_state_e;

    function automatic memb_t fuzzify(rate_t r);
        memb_t m;
        if (int'(r) <= KNEE) begin
            m.lo = grade_t'(KNEE - int'(r));
            m.md = grade_t'(r);
            m.hi = '0;
        end else begin
            m.lo = '0;
            m.md = grade_t'(RATE_MAX - int'(r));
            m.hi = grade_t'(int'(r) - KNEE);
        end
        return m;
    endfunction

    function automatic grade_t gmin(grade_t a, grade_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic grade_t gmax(grade_t a, grade_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic grade_t memb_get(memb_t m, int s);
        case (s)
            0:       return m.lo;
            1:       return m.md;
            default: return m.hi;
        endcase
    endfunction

    function automatic wnum_t sg_value(int lv);
        int v;
        v = lv * (KNEE / 2);
        if (v > RATE_MAX) v = RATE_MAX;
        return wnum_t'(v);
    endfunction

endpackage

// File: rtl/fra_fuzzify.sv
module fra_fuzzify
    import fra_pkg::*;
#(
    parameter int NREQ = 3
) (
    input  logic [NREQ*RATE_W-1:0] rate_i,
    output memb_t                  memb_o [NREQ]
);

    for (genvar i = 0; i < NREQ; i++) begin : g_fz
        always_comb begin
            memb_o[i] = fuzzify(rate_i[i*RATE_W +: RATE_W]);
        end
    end

endmodule

// File: rtl/fra_rules.sv
module fra_rules
    import fra_pkg::*;
#(
    parameter int NREQ = 3,
    parameter int IDX  = 0
) (
    input  logic [NREQ-1:0] req_i,
    input  memb_t           memb_i [NREQ],
    output wnum_t           num_o,
    output wsum_t           den_o
);

    grade_t own_g  [NSET];
    grade_t comp_g [NSET];
    grade_t fire   [NSET][NSET];
    grade_t agg    [NLEVEL];

    // competitor grades: strongest grade among the other active inputs
    always_comb begin
        for (int s = 0; s < NSET; s++) begin
            own_g[s]  = memb_get(memb_i[IDX], s);
            comp_g[s] = '0;
            for (int j = 0; j < NREQ; j++) begin
                if (j != IDX && req_i[j]) begin
                    comp_g[s] = gmax(comp_g[s], memb_get(memb_i[j], s));
                end
            end
        end
    end

    // rule firing (min) and aggregation per singleton level (max)
    always_comb begin
        for (int lv = 0; lv < NLEVEL; lv++) agg[lv] = '0;
        for (int x = 0; x < NSET; x++) begin
            for (int y = 0; y < NSET; y++) begin
                fire[x][y] = gmin(own_g[x], comp_g[y]);
                for (int lv = 0; lv < NLEVEL; lv++) begin
                    if ((NSET - 1) + y - x == lv) begin
                        agg[lv] = gmax(agg[lv], fire[x][y]);
                    end
                end
            end
        end
    end

    // weighted-average terms; an idle input gets a harmless 0/1
    always_comb begin
        wnum_t nsum;
        wsum_t dsum;
        nsum = '0;
        dsum = '0;
        for (int lv = 0; lv < NLEVEL; lv++) begin
            nsum = nsum + wnum_t'(agg[lv]) * sg_value(lv);
            dsum = dsum + wsum_t'(agg[lv]);
        end
        if (req_i[IDX]) begin
            num_o = nsum;
            den_o = dsum;
        end else begin
            num_o = '0;
            den_o = wsum_t'(1);
        end
    end

endmodule

// File: rtl/fra_divider.sv
module fra_divider #(
    parameter int NW = 19,
    parameter int DW = 11,
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic [QW-1:0] quo_o,
    output logic          done_o
);

    localparam int CW = (QW > 1) ? $clog2(QW) : 1;

    logic [NW-1:0] rem_q;
    logic [NW-1:0] dsh_q;
    logic [CW-1:0] step_q;
    logic          busy_q;
    logic          fits;

    assign fits = (rem_q >= dsh_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            dsh_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            quo_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i) begin
                rem_q  <= num_i;
                dsh_q  <= NW'(den_i) << (QW - 1);
                step_q <= '0;
                busy_q <= 1'b1;
                quo_o  <= '0;
            end else if (busy_q) begin
                if (fits) rem_q <= rem_q - dsh_q;
                quo_o  <= {quo_o[QW-2:0], fits};
                dsh_q  <= dsh_q >> 1;
                step_q <= step_q + 1'b1;
                if (step_q == CW'(QW - 1)) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R7
    load_den_nz_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (den_i != '0));

    // R9
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !busy_q);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/fuzzy_req_arbiter.sv
module fuzzy_req_arbiter
    import fra_pkg::*;
#(
    parameter int NREQ = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [NREQ-1:0]        req_i,
    input  logic [NREQ*RATE_W-1:0] rate_i,
    output logic [NREQ-1:0]        grant_o,
    output logic                   grant_valid_o
);

    localparam int QUO_W = RATE_W;
    localparam int IDXW  = (NREQ > 1) ? $clog2(NREQ) : 1;

    arb_state_e             state_q;
    logic [NREQ-1:0]        req_q;
    logic [NREQ*RATE_W-1:0] rate_q;

    memb_t                  memb [NREQ];
    wnum_t                  num  [NREQ];
    wsum_t                  den  [NREQ];
    logic [QUO_W-1:0]       quo  [NREQ];
    logic [NREQ-1:0]        done;
    logic                   div_load;

    logic [IDXW-1:0]        best_idx;
    logic [QUO_W-1:0]       best_q;
    logic                   found;

    assign div_load = (state_q == ST_INFER);

    fra_fuzzify #(.NREQ(NREQ)) u_fuzz (
        .rate_i (rate_q),
        .memb_o (memb)
    );

    for (genvar i = 0; i < NREQ; i++) begin : g_lane
        fra_rules #(.NREQ(NREQ), .IDX(i)) u_rules (
            .req_i  (req_q),
            .memb_i (memb),
            .num_o  (num[i]),
            .den_o  (den[i])
        );

        fra_divider #(.NW(NUM_W), .DW(AGG_W), .QW(QUO_W)) u_div (
            .clk    (clk),
            .rst    (rst),
            .load_i (div_load),
            .num_i  (num[i]),
            .den_i  (den[i]),
            .quo_o  (quo[i]),
            .done_o (done[i])
        );
    end

    // highest score wins; strict compare keeps the lowest index on ties
    always_comb begin
        best_idx = '0;
        best_q   = '0;
        found    = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (req_q[i] && (!found || quo[i] > best_q)) begin
                best_idx = IDXW'(i);
                best_q   = quo[i];
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            req_q         <= '0;
            rate_q        <= '0;
            grant_o       <= '0;
            grant_valid_o <= 1'b0;
        end else begin
            grant_o       <= '0;
            grant_valid_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q  <= req_i;
                        rate_q <= rate_i;
                        if ($countones(req_i) == 1) begin
                            grant_o       <= req_i;
                            grant_valid_o <= 1'b1;
                        end else if ($countones(req_i) > 1) begin
                            state_q <= ST_INFER;
                        end
                    end
                end
                ST_INFER: begin
                    state_q <= ST_DIVIDE;
                end
                ST_DIVIDE: begin
                    if (&done) begin
                        grant_o       <= {{(NREQ-1){1'b0}}, 1'b1} << best_idx;
                        grant_valid_o <= 1'b1;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> ($countones(grant_o) == 1));

    // R8
    grant_in_req_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> ((grant_o & ~req_q) == '0));

    // R1
    idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !grant_valid_o |-> (grant_o == '0));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIVIDE) |-> !grant_valid_o);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(req_q));

endmodule

// File: tb/fuzzy_req_arbiter_tb.sv
module fuzzy_req_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT_MULTI  = 10;   // R4: ten edges after the sampling edge
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  req_i = '0;
    logic [23:0] rate_i = '0;
    logic [2:0]  grant_o;
    logic        grant_valid_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    typedef struct {
        logic [2:0] grant;
        int         due;
        string      tag;
    } exp_t;

    exp_t sb [$];

    fuzzy_req_arbiter u_dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .req_i         (req_i),
        .rate_i        (rate_i),
        .grant_o       (grant_o),
        .grant_valid_o (grant_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R5: membership grades, set 0 low, 1 medium, 2 high
    function automatic int grade(int r, int s);
        if (r <= 128) return (s == 0) ? 128 - r : (s == 1) ? r : 0;
        return (s == 0) ? 0 : (s == 1) ? 255 - r : r - 128;
    endfunction

    // R6 and R7: score of requester idx
    function automatic int model_score(int idx, logic [2:0] rq, logic [23:0] rt);
        int comp [3];
        int own [3];
        int agg [5];
        int num, den, w, lv, sg;
        for (int s = 0; s < 3; s++) begin
            own[s]  = grade(int'(rt[idx*8 +: 8]), s);
            comp[s] = 0;
            for (int j = 0; j < 3; j++)
                if (j != idx && rq[j] && grade(int'(rt[j*8 +: 8]), s) > comp[s])
                    comp[s] = grade(int'(rt[j*8 +: 8]), s);
        end
        for (int k = 0; k < 5; k++) agg[k] = 0;
        for (int x = 0; x < 3; x++)
            for (int y = 0; y < 3; y++) begin
                w  = (own[x] < comp[y]) ? own[x] : comp[y];
                lv = 2 + y - x;
                if (w > agg[lv]) agg[lv] = w;
            end
        num = 0;
        den = 0;
        for (int k = 0; k < 5; k++) begin
            sg  = (64 * k > 255) ? 255 : 64 * k;
            num = num + agg[k] * sg;
            den = den + agg[k];
        end
        return num / den;
    endfunction

    // R8: highest score, lowest index on ties
    function automatic logic [2:0] model_winner(logic [2:0] rq, logic [23:0] rt);
        int best = -1;
        int bi = 0;
        int sc;
        for (int i = 0; i < 3; i++)
            if (rq[i]) begin
                sc = model_score(i, rq, rt);
                if (sc > best) begin
                    best = sc;
                    bi = i;
                end
            end
        return 3'b001 << bi;
    endfunction

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (grant_valid_o || grant_o != 3'b000) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    // driver: strobe one round and push the expected grant
    task automatic issue(input logic [2:0] rq, input int a, input int b, input int c,
                         input string tag);
        exp_t e;
        logic [23:0] rt;
        int cnt;
        rt  = {8'(c), 8'(b), 8'(a)};
        cnt = $countones(rq);
        @(negedge clk);
        req_i   = rq;
        rate_i  = rt;
        start_i = 1'b1;
        if (cnt == 1) begin
            e.grant = rq;
            e.due   = cyc + 1;
            e.tag   = tag;
            sb.push_back(e);
        end else if (cnt > 1) begin
            e.grant = model_winner(rq, rt);
            e.due   = cyc + 1 + LAT_MULTI;
            e.tag   = tag;
            sb.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b0;
        if (cnt == 0) quiet(LAT_MULTI + 2, "R3 empty request");
        else repeat ((cnt == 1) ? 1 : LAT_MULTI + 1) @(negedge clk);
    endtask

    // monitor: compare results against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (sb.size() > 0 && cyc > sb[0].due) begin
                check(1'b0, {sb[0].tag, " missing grant"}, 0, int'(sb[0].grant));
                void'(sb.pop_front());
            end
            if (grant_valid_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 R3 unexpected grant", int'(grant_o), 0);
                end else begin
                    check(grant_o == sb[0].grant, {sb[0].tag, " grant"},
                          int'(grant_o), int'(sb[0].grant));
                    check(cyc == sb[0].due, {sb[0].tag, " R4 R2 latency"}, cyc, sb[0].due);
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed = 32'h1234_5678;
        logic [2:0] rq;
        int a, b, c;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(grant_o == 3'b000 && !grant_valid_o, "R1 in reset",
              int'({grant_valid_o, grant_o}), 0);
        rst = 1'b0;
        quiet(3, "R1 after reset");

        // R2 bypass on each single input
        issue(3'b001, 10, 0, 0, "R2 single in0");
        issue(3'b100, 0, 0, 255, "R2 single in2");
        issue(3'b010, 0, 77, 0, "R2 single in1");

        // R3 nothing requested
        issue(3'b000, 5, 6, 7, "R3 none");

        // starved versus served, both orders
        issue(3'b011, 0, 255, 0, "R5 R6 R7 starved in0");
        issue(3'b011, 255, 0, 0, "R5 R6 R7 starved in1");
        issue(3'b011, 200, 50, 0, "R6 R7 mixed pair");
        issue(3'b101, 90, 0, 140, "R6 R7 pair in0 in2");

        // ties
        issue(3'b011, 128, 128, 0, "R8 tie pair");
        issue(3'b110, 0, 128, 128, "R8 tie upper pair");
        issue(3'b111, 30, 30, 200, "R8 tie three");
        issue(3'b111, 0, 0, 0, "R8 tie all zero");
        issue(3'b111, 100, 60, 90, "R6 R8 three way");

        // R9 strobe during a busy round
        @(negedge clk);
        req_i   = 3'b110;
        rate_i  = {8'd20, 8'd240, 8'd0};
        start_i = 1'b1;
        begin
            exp_t e;
            e.grant = model_winner(3'b110, {8'd20, 8'd240, 8'd0});
            e.due   = cyc + 1 + LAT_MULTI;
            e.tag   = "R9 busy round";
            sb.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        req_i   = 3'b001;
        rate_i  = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT_MULTI) @(negedge clk);
        quiet(4, "R9 ignored strobe");

        // sweep
        for (int k = 0; k < 24; k++) begin
            seed = seed * 1103515245 + 12345;
            a  = (seed >>> 8) & 255;
            seed = seed * 1103515245 + 12345;
            b  = (seed >>> 8) & 255;
            seed = seed * 1103515245 + 12345;
            c  = (seed >>> 8) & 255;
            rq = (k % 4 == 0) ? 3'b011 : (k % 4 == 1) ? 3'b101 :
                 (k % 4 == 2) ? 3'b110 : 3'b111;
            issue(rq, a, b, c, "R5 R6 R7 R8 sweep");
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule